// File: doc/BRIEF.md
# Watchdog Timer with Unlock-Gated Configuration

This block is a watchdog built from a selectable prescaler and an 8-bit down counter, driven from a small register bus. Software stages a control byte and a reload byte. Neither value affects the running timer until a two-write unlock pair arrives on the bus. The unlock pair is called a feed. When a feed completes, both staged bytes are copied at once into the active control shadow, and the reload value is queued for the down counter.

The watchdog reset output pulses if software breaks the feed protocol. It also pulses if the counter underflows because software did not feed it in time. The pulse is a single registered cycle, so the surrounding system can use it directly as a reset request.

Register map (3-bit address): 0 = staged control, 1 = staged reload, 2 = first unlock register, 3 = second unlock register, 4 = live counter value (read only). Control byte fields: bit 0 = watchdog mode, bit 2 = run enable, bits 7:5 = prescaler select.

Top module: `wdog_feed`

## Requirements
- R1: After system reset, `wdt_rst_o` is 0. Reads of the staged control (address 0), the staged reload (address 1) and the counter (address 4) return 0. The watchdog is stopped.
- R2: A read at address 0 returns the last byte written there, and a read at address 1 returns the last byte written there. Reads of the unlock registers (addresses 2 and 3) return 0. When `rd_en_i` is low, `rdata_o` is 0.
- R3: Writes to addresses 0 and 1 do not change the active configuration or the counting until a feed completes.
- R4: A feed is a write of A5h to address 2 followed by a write of 5Ah to address 3. Reads between the two writes are allowed. The feed copies the staged control into the active shadow in the cycle of the second write, and the feed raises no reset.
- R5: Any bus write that breaks the feed protocol raises `wdt_rst_o` in the cycle after that write. This covers a write to address 3 with no pending first half, a first-half write with data other than A5h, and any write after A5h other than 5Ah to address 3.
- R6: While the active watchdog-mode bit (control bit 0) is 1, a write to the control register must be directly followed by a write of A5h to address 2. Any other next write raises `wdt_rst_o`.
- R7: The prescaler select (control bits 7:5), with value s, sets the counter tick period to 32·2^s clock cycles. This gives 32 for s = 0 up to 4096 for s = 7.
- R8: When the active run bit (control bit 2) is 0, the counter holds its value and no underflow reset occurs.
- R9: The reload value reaches the counter one tick period after the feed. After that, the counter decrements once per tick. A tick taken at a count of 0 is an underflow: it reloads the counter and raises the reset. The first reset therefore comes (reload+2)·period cycles after the feed.
- R10: `wdt_rst_o` is a registered pulse of one cycle for each offending write or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
On every cycle, the assertions check four things. The active shadow changes only on a completed feed. The counter moves only by a decrement or by a reload from the committed value. The counter holds still while stopped. Every reset pulse traces back to a bus write or an underflow. Other properties need the bench's scenarios, because each depends on long stretches of history or on the order of bus writes. These are the exact cycle of the first underflow for each prescaler code, the one-period delay before the reload lands, the ignored staging while the watchdog runs, and the control-then-feed rule in watchdog mode.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic [1:0] {
      FS_IDLE   = 2'd0,
      FS_ARMED  = 2'd1,
      FS_CTRL_W = 2'd2
   } feed_state_e;

   localparam int unsigned MODE_BIT = 0;
   localparam int unsigned RUN_BIT  = 2;
   localparam int unsigned SEL_LSB  = 5;

   localparam int unsigned ADR_CTRL   = 0;
   localparam int unsigned ADR_RELOAD = 1;
   localparam int unsigned ADR_KEY_A  = 2;
   localparam int unsigned ADR_KEY_B  = 3;
   localparam int unsigned ADR_COUNT  = 4;
endpackage

// File: rtl/wdog_feed_fsm.sv
module wdog_feed_fsm
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter logic [7:0]  KEY_A  = 8'hA5,
   parameter logic [7:0]  KEY_B  = 8'h5A
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              mode_i,
   output logic              commit_o,
   output logic              feed_err_o,
   output feed_state_e       state_o
);
   localparam logic [DATA_W-1:0] KEY_A_W = DATA_W'(KEY_A);
   localparam logic [DATA_W-1:0] KEY_B_W = DATA_W'(KEY_B);

   feed_state_e state_q, state_d;
   logic hit_a, hit_b, hit_ctrl, key_a_ok, key_b_ok;

   assign hit_a    = (addr_i == ADDR_W'(ADR_KEY_A));
   assign hit_b    = (addr_i == ADDR_W'(ADR_KEY_B));
   assign hit_ctrl = (addr_i == ADDR_W'(ADR_CTRL));
   assign key_a_ok = hit_a && (wdata_i == KEY_A_W);
   assign key_b_ok = hit_b && (wdata_i == KEY_B_W);

   always_comb begin
      state_d    = state_q;
      commit_o   = 1'b0;
      feed_err_o = 1'b0;
      if (wr_en_i) begin
         case (state_q)
            FS_IDLE: begin
               if (hit_a) begin
                  if (key_a_ok) state_d = FS_ARMED;
                  else          feed_err_o = 1'b1;
               end else if (hit_b) begin
                  feed_err_o = 1'b1;
               end else if (hit_ctrl && mode_i) begin
                  state_d = FS_CTRL_W;
               end
            end
            FS_ARMED: begin
               state_d = FS_IDLE;
               if (key_b_ok) commit_o   = 1'b1;
               else          feed_err_o = 1'b1;
            end
            FS_CTRL_W: begin
               if (key_a_ok) begin
                  state_d = FS_ARMED;
               end else begin
                  state_d    = FS_IDLE;
                  feed_err_o = 1'b1;
               end
            end
            default: begin
               state_d    = FS_IDLE;
               feed_err_o = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= FS_IDLE;
      else         state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              commit_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [DATA_W-1:0] ctrl_stg_o,
   output logic [DATA_W-1:0] ctrl_sh_o,
   output logic [CNT_W-1:0]  reload_stg_o,
   output logic [CNT_W-1:0]  reload_sh_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] ctrl_stg_q, ctrl_sh_q;
   logic [CNT_W-1:0]  reload_stg_q, reload_sh_q;
   logic [DATA_W-1:0] rd_mux;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_stg_q   <= '0;
         reload_stg_q <= '0;
      end else if (wr_en_i) begin
         if (addr_i == ADDR_W'(ADR_CTRL))   ctrl_stg_q   <= wdata_i;
         if (addr_i == ADDR_W'(ADR_RELOAD)) reload_stg_q <= wdata_i[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_sh_q   <= '0;
         reload_sh_q <= '0;
      end else if (commit_i) begin
         ctrl_sh_q   <= ctrl_stg_q;
         reload_sh_q <= reload_stg_q;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (addr_i == ADDR_W'(ADR_CTRL))   rd_mux = ctrl_stg_q;
      if (addr_i == ADDR_W'(ADR_RELOAD)) rd_mux = DATA_W'(reload_stg_q);
      if (addr_i == ADDR_W'(ADR_COUNT))  rd_mux = DATA_W'(count_i);
   end

   assign rdata_o      = rd_en_i ? rd_mux : '0;
   assign ctrl_stg_o   = ctrl_stg_q;
   assign ctrl_sh_o    = ctrl_sh_q;
   assign reload_stg_o = reload_stg_q;
   assign reload_sh_o  = reload_sh_q;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned MIN_LOG2 = 5,
   parameter int unsigned STYLE    = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             clear_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int unsigned PS_W = MIN_LOG2 + (1 << SEL_W) - 1;

   logic [PS_W-1:0] ps_q;
   logic [PS_W-1:0] limit;

   // all-ones mask of the selected period; the top code wraps to full width
   assign limit = (PS_W'(1) << (MIN_LOG2 + 32'(sel_i))) - PS_W'(1);

   generate
      if (STYLE == 0) begin : g_match
         assign tick_o = run_i && (ps_q == limit);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      ps_q <= '0;
            else if (clear_i) ps_q <= '0;
            else if (run_i)   ps_q <= tick_o ? '0 : ps_q + PS_W'(1);
         end
      end else begin : g_mask
         assign tick_o = run_i && ((ps_q & limit) == limit);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      ps_q <= '0;
            else if (clear_i) ps_q <= '0;
            else if (run_i)   ps_q <= ps_q + PS_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             commit_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             underflow_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;

   assign underflow_o = tick_i && !pend_q && (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q <= 1'b0;
      else if (commit_i) pend_q <= 1'b1;
      else if (tick_i)   pend_q <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (pend_q || cnt_q == '0) cnt_q <= reload_i;
         else                       cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/wdog_feed.sv
module wdog_feed
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned MIN_LOG2 = 5,
   parameter int unsigned PS_STYLE = 0,
   parameter logic [7:0]  KEY_A    = 8'hA5,
   parameter logic [7:0]  KEY_B    = 8'h5A
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              wdt_rst_o
);
   initial begin
      assert (DATA_W >= 8) else $error("data width below key width");
      assert (CNT_W <= DATA_W) else $error("counter wider than bus");
      assert (SEL_LSB + SEL_W <= DATA_W) else $error("select field off bus");
      assert (ADDR_W >= 3) else $error("address too narrow for map");
      assert (PS_STYLE <= 1) else $error("unknown prescaler style");
   end

   logic              commit, feed_err, tick, underflow, run, mode;
   feed_state_e       feed_state;
   logic [DATA_W-1:0] ctrl_stg, ctrl_sh;
   logic [CNT_W-1:0]  reload_stg, reload_sh, count;
   logic [SEL_W-1:0]  sel;
   logic              rst_q;

   assign run  = ctrl_sh[RUN_BIT];
   assign mode = ctrl_sh[MODE_BIT];
   assign sel  = ctrl_sh[SEL_LSB +: SEL_W];

   wdog_feed_fsm #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .mode_i(mode), .commit_o(commit),
      .feed_err_o(feed_err), .state_o(feed_state)
   );

   wdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .commit_i(commit), .count_i(count),
      .ctrl_stg_o(ctrl_stg), .ctrl_sh_o(ctrl_sh), .reload_stg_o(reload_stg),
      .reload_sh_o(reload_sh), .rdata_o(rdata_o)
   );

   wdog_prescaler #(
      .SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2), .STYLE(PS_STYLE)
   ) u_ps (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clear_i(commit),
      .sel_i(sel), .tick_o(tick)
   );

   wdog_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .commit_i(commit),
      .reload_i(reload_sh), .count_o(count), .underflow_o(underflow)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rst_q <= 1'b0;
      else         rst_q <= feed_err || underflow;
   end

   assign wdt_rst_o = rst_q;
endmodule

// File: rtl/wdog_feed_chk.sv
module wdog_feed_chk
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 8,
   parameter logic [7:0]  KEY_B  = 8'h5A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              rst_o,
   input logic              commit,
   input feed_state_e       state,
   input logic [DATA_W-1:0] ctrl_stg,
   input logic [DATA_W-1:0] ctrl_sh,
   input logic              run,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  reload_sh,
   input logic              underflow
);
   // R10
   pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |-> ($past(wr_en) || $past(underflow)));

   // R4
   shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (ctrl_sh == $past(ctrl_stg)));

   // R3
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(ctrl_sh));

   // R8
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(count));

   // R9
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |->
         ((count == CNT_W'($past(count) - 1'b1)) || (count == $past(reload_sh))));

   // R5
   armed_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FS_ARMED && wr_en &&
       !(addr == ADDR_W'(ADR_KEY_B) && wdata == DATA_W'(KEY_B))) |=> rst_o);

   // R2
   key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == ADDR_W'(ADR_KEY_A) || addr == ADDR_W'(ADR_KEY_B)))
         |-> (rdata == '0));
endmodule

bind wdog_feed wdog_feed_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .KEY_B(KEY_B)
) u_chk (
   .clk(clk_i), .rst_n(rst_ni), .wr_en(wr_en_i), .rd_en(rd_en_i),
   .addr(addr_i), .wdata(wdata_i), .rdata(rdata_o), .rst_o(wdt_rst_o),
   .commit(commit), .state(feed_state), .ctrl_stg(ctrl_stg),
   .ctrl_sh(ctrl_sh), .run(run), .count(count), .reload_sh(reload_sh),
   .underflow(underflow)
);

// File: tb/wdog_feed_tb.sv
module wdog_feed_tb_top;
   localparam logic [2:0] A_CTRL = 3'd0, A_REL = 3'd1, A_KA = 3'd2,
                          A_KB = 3'd3, A_CNT = 3'd4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       wdt_rst;

   int checks = 0;
   int fails  = 0;

   // bench model of the staged registers and feed protocol
   logic [7:0] m_ctrl = '0, m_rel = '0;
   bit         m_mode = 1'b0;
   int         m_st = 0;   // 0 idle, 1 armed, 2 waiting after control write

   always #10 clk = ~clk;

   wdog_feed dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_o(wdt_rst)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int period(input int sel);
      return 32 << sel;
   endfunction

   task automatic model_write(input logic [2:0] a, input logic [7:0] d,
                              output bit err);
      err = 1'b0;
      case (m_st)
         0: begin
            if (a == A_KA) begin
               if (d == 8'hA5) m_st = 1; else err = 1'b1;
            end else if (a == A_KB) err = 1'b1;
            else if (a == A_CTRL && m_mode) m_st = 2;
         end
         1: begin
            m_st = 0;
            if (a == A_KB && d == 8'h5A) m_mode = m_ctrl[0];
            else err = 1'b1;
         end
         default: begin
            if (a == A_KA && d == 8'hA5) m_st = 1;
            else begin m_st = 0; err = 1'b1; end
         end
      endcase
      if (a == A_CTRL) m_ctrl = d;
      if (a == A_REL)  m_rel  = d;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d,
                            input string req);
      bit err;
      model_write(a, d, err);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      check(req, int'(wdt_rst), int'(err));
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      #1 rd_en = 1'b0;
   endtask

   task automatic commit_cfg(input logic [7:0] c, input logic [7:0] r,
                             input string req);
      bus_write(A_REL, r, req);
      bus_write(A_CTRL, c, req);
      bus_write(A_KA, 8'hA5, req);
      bus_write(A_KB, 8'h5A, req);
   endtask

   // waits for the first underflow at exactly 'cyc' cycles after the feed
   task automatic expect_underflow(input int cyc, input string req);
      int early = 0;
      for (int n = 1; n <= cyc; n++) begin
         @(negedge clk);
         if (n < cyc && wdt_rst) early++;
      end
      check({req, " early pulse"}, early, 0);
      check({req, " pulse at expected cycle"}, int'(wdt_rst), 1);
      @(negedge clk);
      check("R10 pulse lasts one cycle", int'(wdt_rst), 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v, exp_v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 reset pulse low", int'(wdt_rst), 0);
      peek(A_CTRL, v); check("R1 staged control zero", v, 0);
      peek(A_REL, v);  check("R1 staged reload zero", v, 0);
      peek(A_CNT, v);  check("R1 counter zero", v, 0);

      // R2 directed readback
      bus_write(A_CTRL, 8'hE0, "R2 control write");
      bus_write(A_REL, 8'h3C, "R2 reload write");
      peek(A_CTRL, v); check("R2 control readback", v, 8'hE0);
      peek(A_REL, v);  check("R2 reload readback", v, 8'h3C);
      peek(A_KA, v);   check("R2 first key reads zero", v, 0);
      peek(A_KB, v);   check("R2 second key reads zero", v, 0);
      #1 check("R2 rdata idle zero", int'(rdata), 0);

      // constrained random register traffic, watchdog kept stopped
      for (int i = 0; i < 400; i++) begin
         int op = $urandom_range(0, 5);
         case (op)
            0: bus_write(A_CTRL, 8'($urandom) & 8'hFB, "R6 random control");
            1: bus_write(A_REL, 8'($urandom), "R3 random reload");
            2: bus_write(A_KA, $urandom_range(0, 1) ? 8'hA5 : 8'($urandom),
                         "R5 random first key");
            3: bus_write(A_KB, $urandom_range(0, 1) ? 8'h5A : 8'($urandom),
                         "R5 random second key");
            default: begin
               logic [2:0] ra = 3'($urandom_range(0, 4));
               @(negedge clk);
               peek(ra, v);
               exp_v = (ra == A_CTRL) ? m_ctrl : (ra == A_REL) ? m_rel : 8'h00;
               check("R2 random readback", v, exp_v);
            end
         endcase
      end
      peek(A_CNT, v); check("R8 counter untouched while stopped", v, 0);
      // bring protocol back to idle: this write always breaks it
      bus_write(A_KB, 8'h00, "R5 resync write");

      // R5 directed breaks
      bus_write(A_KB, 8'h5A, "R5 second half without first");
      bus_write(A_KA, 8'h55, "R5 wrong first key");
      bus_write(A_KA, 8'hA5, "R5 first key");
      bus_write(A_CTRL, 8'h00, "R5 write between halves");
      // R4 feed with a read between the halves
      bus_write(A_KA, 8'hA5, "R4 first key");
      @(negedge clk); peek(A_CTRL, v);
      bus_write(A_KB, 8'h5A, "R4 second key after read");

      // R6 control write in watchdog mode must be followed by a feed
      commit_cfg(8'h01, 8'h10, "R6 enter watchdog mode");
      bus_write(A_CTRL, 8'h01, "R6 control write");
      bus_write(A_REL, 8'h10, "R6 reload after control breaks");
      bus_write(A_CTRL, 8'h01, "R6 control write");
      bus_write(A_KA, 8'hA5, "R6 feed follows control");
      bus_write(A_KB, 8'h5A, "R6 feed completes");

      // R9 timing, R3 staged writes ignored while running
      begin
         int early = 0;
         bit err;
         commit_cfg(8'h05, 8'h03, "R9 start run");
         for (int n = 1; n <= 161; n++) begin
            @(negedge clk);
            if (wr_en) wr_en = 1'b0;
            if (n == 31) begin peek(A_CNT, v); check("R9 reload not yet loaded", v, 0); end
            if (n == 32) begin peek(A_CNT, v); check("R9 reload after one period", v, 3); end
            if (n == 64) begin peek(A_CNT, v); check("R9 first decrement", v, 2); end
            if (n == 40) begin
               model_write(A_REL, 8'd200, err);
               wr_en = 1'b1; addr = A_REL; wdata = 8'd200;
            end
            if (n < 160 && wdt_rst) early++;
            if (n == 160) check("R3 underflow unchanged by staged reload", int'(wdt_rst), 1);
            if (n == 161) begin
               check("R10 single cycle pulse", int'(wdt_rst), 0);
               peek(A_CNT, v); check("R9 reload after underflow", v, 3);
            end
         end
         check("R9 no early pulse", early, 0);
      end

      // R4 regular feeding keeps the watchdog quiet (reload 200 now committed)
      begin
         int seen = 0;
         for (int k = 0; k < 5; k++) begin
            bus_write(A_KA, 8'hA5, "R4 keepalive first key");
            bus_write(A_KB, 8'h5A, "R4 keepalive second key");
            for (int n = 0; n < 60; n++) begin
               @(negedge clk);
               if (wdt_rst) seen++;
            end
         end
         check("R4 fed watchdog never fires", seen, 0);
      end

      // R7 every prescaler code
      for (int s = 0; s < 8; s++) begin
         int r = s % 3;
         commit_cfg({3'(s), 5'b00101}, 8'(r), "R7 configure");
         expect_underflow((r + 2) * period(s), $sformatf("R7 select %0d", s));
      end

      // R8 stop holds the counter
      begin
         logic [7:0] c0;
         int seen = 0;
         commit_cfg(8'h01, 8'h05, "R8 stop");
         @(negedge clk); peek(A_CNT, c0);
         for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            if (wdt_rst) seen++;
         end
         peek(A_CNT, v);
         check("R8 counter frozen", v, c0);
         check("R8 no pulse while stopped", seen, 0);
      end

      finish_run();
   end
endmodule